// File: doc/BRIEF.md
# Single-Multiplier Four-Tap FIR Filter

This block is a four-tap finite impulse response filter that spends one multiplier on all four tap products. Samples arrive at a base rate of at most one every four clock cycles. For each accepted sample, the delay line shifts once. A sequencer then drives the shared multiplier through four steps, one coefficient and tap pair per step, and adds the products into an accumulator. A registered output presents one filtered result per accepted sample.

The four coefficients are fed as one flat vector and are used as they are presented. They must be held steady while a sample is in flight. Both the incoming sample and the outgoing result pass through a boundary register. An input strobe that lands while a four-step run is still busy is dropped, and a sticky overrun flag records it.

The sequencer has two states. `SEQ_IDLE` waits for a sample. `SEQ_RUN` steps a 2-bit counter from 0 to 3. The transitions are:
- `idle_to_run`: a registered sample arrives while idle.
- `run_step`: step 0, 1 or 2 moves to the next step.
- `run_chain`: step 3 coincides with a new registered sample. The counter restarts at 0 and the state stays in `SEQ_RUN`.
- `run_to_idle`: step 3 with no new sample.

Top module: `tdm_fir4`

## Requirements
- R1: After reset, `res_valid_o` is 0, `res_data_o` is 0 and `ovr_o` is 0, and the delay line holds zeros.
- R2: The result for an accepted sample x[n] is c0·x[n] + c1·x[n-1] + c2·x[n-2] + c3·x[n-3]. Tap k's coefficient is `coef_i[k*CW +: CW]`. Earlier samples that were never accepted since reset count as zero.
- R3: A result appears exactly six clock edges after the edge that samples `smp_valid_i` high. One edge is taken by the input register, one by the shift, four by the multiply steps, and one by the output register, counted from the sampling edge.
- R4: `res_valid_o` is high for exactly one clock per accepted sample.
- R5: Samples spaced exactly four cycles apart are all accepted, with results four cycles apart.
- R6: A strobe registered while the sequence is at step 0, 1 or 2 is ignored. It produces no result and does not shift the delay line, so the next results use the earlier history.
- R7: An ignored strobe sets `ovr_o`, which stays 1 until reset.
- R8: Samples and coefficients are signed two's complement. Four full-scale products, (-2^(DW-1))·(-2^(CW-1)) each, sum without overflow in the DW+CW+2-bit result.
- R9: The step counter advances by one on each `SEQ_RUN` cycle before step 3. The multiply at step s uses tap s and coefficient s, and the accumulator restarts on step 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid_i | input | 1 | Sample strobe, one cycle per sample |
| smp_data_i | input | DW | Signed input sample |
| coef_i | input | 4*CW | Four signed coefficients, tap k at bits k*CW +: CW |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_data_o | output | DW+CW+2 | Signed filtered result |
| ovr_o | output | 1 | Sticky overrun flag |

## Verification
Each test pattern isolates a different fault:
- **Impulse with ramp coefficients:** shows whether taps and coefficients pair up in the right order, since each output reads back exactly one coefficient.
- **Mixed-sign samples with negative coefficients, at idle gaps and at the minimum four-cycle spacing:** separates sign handling from the `run_chain` restart path.
- **Strobe injected one cycle into a run:** shows whether it wrongly shifted the history or produced an extra result.
- **All-minimum samples and coefficients:** exposes a truncated accumulator.

// File: rtl/tdm_fir_pkg.sv
package tdm_fir_pkg;
    localparam int unsigned NTAP = 4;
    localparam int unsigned SW   = $clog2(NTAP);

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;
endpackage

// File: rtl/fir_seq.sv
module fir_seq
    import tdm_fir_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_vld_i,
    output logic          accept_o,
    output logic [SW-1:0] step_o,
    output logic          first_o,
    output logic          mac_en_o,
    output logic          fin_o,
    output logic          ovr_o
);
    localparam logic [SW-1:0] STEP_LAST = SW'(NTAP - 1);

    seq_state_t    st_q, st_d;
    logic [SW-1:0] step_q;
    logic          fin_q, ovr_q;
    logic          last;

    assign last     = (st_q == SEQ_RUN) && (step_q == STEP_LAST);
    assign accept_o = smp_vld_i && ((st_q == SEQ_IDLE) || last);
    assign first_o  = (st_q == SEQ_RUN) && (step_q == '0);
    assign mac_en_o = (st_q == SEQ_RUN);
    assign step_o   = step_q;
    assign fin_o    = fin_q;
    assign ovr_o    = ovr_q;

    // next-state decode
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SEQ_IDLE: if (smp_vld_i) st_d = SEQ_RUN;             // idle_to_run
            SEQ_RUN:  if (last && !smp_vld_i) st_d = SEQ_IDLE;   // run_to_idle
            default:  st_d = SEQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SEQ_IDLE;
        else        st_q <= st_d;
    end

    // outputs: step counter, finish flag, sticky overrun
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
            fin_q  <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (accept_o)              step_q <= '0;              // idle_to_run / run_chain
            else if (st_q == SEQ_RUN)  step_q <= step_q + SW'(1); // run_step
            fin_q <= last;
            if (smp_vld_i && !accept_o) ovr_q <= 1'b1;
        end
    end

    // R9
    step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SEQ_RUN && step_q != STEP_LAST) |=> (step_q == $past(step_q) + SW'(1)));
    // R7
    sticky_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_q |=> ovr_q);
    // R6
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld_i && st_q == SEQ_RUN && step_q != STEP_LAST) |=> ovr_q);
endmodule

// File: rtl/fir_taps.sv
module fir_taps
    import tdm_fir_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_i,
    input  logic signed [DW-1:0] din_i,
    input  logic [SW-1:0]        sel_i,
    output logic signed [DW-1:0] tap_o
);
    logic signed [DW-1:0] line_q [NTAP];

    for (genvar g = 0; g < NTAP; g++) begin : g_line
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (!rst_n)       line_q[g] <= '0;
                else if (shift_i) line_q[g] <= din_i;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (!rst_n)       line_q[g] <= '0;
                else if (shift_i) line_q[g] <= line_q[g-1];
            end
        end
    end

    assign tap_o = line_q[sel_i];

    // R6
    hold_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_i |=> $stable(line_q[NTAP-1]));
    // R2
    shift_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |=> (line_q[1] == $past(line_q[0])));
endmodule

// File: rtl/fir_mac.sv
module fir_mac #(
    parameter int unsigned DW = 16,
    parameter int unsigned CW = 16,
    parameter int unsigned AW = DW + CW + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_i,
    input  logic                 clr_i,
    input  logic signed [DW-1:0] a_i,
    input  logic signed [CW-1:0] b_i,
    output logic signed [AW-1:0] acc_o
);
    localparam int unsigned PW = DW + CW;

    logic signed [PW-1:0] prod;
    logic signed [AW-1:0] prod_x;
    logic signed [AW-1:0] acc_q;

    assign prod   = a_i * b_i;
    assign prod_x = AW'(prod);

    always_ff @(posedge clk) begin
        if (!rst_n)     acc_q <= '0;
        else if (en_i)  acc_q <= clr_i ? prod_x : acc_q + prod_x;
    end

    assign acc_o = acc_q;

    // R9
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(acc_q));
endmodule

// File: rtl/tdm_fir4.sv
module tdm_fir4
    import tdm_fir_pkg::*;
#(
    parameter int unsigned DW = 16,
    parameter int unsigned CW = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_valid_i,
    input  logic signed [DW-1:0]     smp_data_i,
    input  logic [4*CW-1:0]          coef_i,
    output logic                     res_valid_o,
    output logic signed [DW+CW+1:0]  res_data_o,
    output logic                     ovr_o
);
    localparam int unsigned AW = DW + CW + 2;

    logic                 in_vld_q;
    logic signed [DW-1:0] in_dat_q;
    logic                 accept, first, mac_en, fin;
    logic [SW-1:0]        step;
    logic signed [DW-1:0] tap;
    logic signed [CW-1:0] coef_a [NTAP];
    logic signed [AW-1:0] acc;

    // input boundary register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_vld_q <= 1'b0;
            in_dat_q <= '0;
        end else begin
            in_vld_q <= smp_valid_i;
            in_dat_q <= smp_data_i;
        end
    end

    for (genvar g = 0; g < NTAP; g++) begin : g_coef
        assign coef_a[g] = coef_i[g*CW +: CW];
    end

    fir_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_vld_i(in_vld_q),
        .accept_o (accept),
        .step_o   (step),
        .first_o  (first),
        .mac_en_o (mac_en),
        .fin_o    (fin),
        .ovr_o    (ovr_o)
    );

    fir_taps #(.DW(DW)) u_taps (
        .clk    (clk),
        .rst_n  (rst_n),
        .shift_i(accept),
        .din_i  (in_dat_q),
        .sel_i  (step),
        .tap_o  (tap)
    );

    fir_mac #(.DW(DW), .CW(CW), .AW(AW)) u_mac (
        .clk  (clk),
        .rst_n(rst_n),
        .en_i (mac_en),
        .clr_i(first),
        .a_i  (tap),
        .b_i  (coef_a[step]),
        .acc_o(acc)
    );

    // output boundary register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid_o <= 1'b0;
            res_data_o  <= '0;
        end else begin
            res_valid_o <= fin;
            if (fin) res_data_o <= acc;
        end
    end

    // R4
    pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |=> !res_valid_o);
    // R3
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid_o |-> $stable(res_data_o) || $past(fin));
endmodule

// File: tb/tdm_fir4_test.sv
module tdm_fir4_test;
    localparam int DW = 16;
    localparam int CW = 16;
    localparam int AW = DW + CW + 2;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 smp_valid_i = 1'b0;
    logic signed [DW-1:0] smp_data_i = '0;
    logic [4*CW-1:0]      coef_i = '0;
    logic                 res_valid_o;
    logic signed [AW-1:0] res_data_o;
    logic                 ovr_o;

    tdm_fir4 #(.DW(DW), .CW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .smp_valid_i(smp_valid_i), .smp_data_i(smp_data_i),
        .coef_i(coef_i), .res_valid_o(res_valid_o), .res_data_o(res_data_o), .ovr_o(ovr_o)
    );

    always #4 clk = ~clk; // 125 MHz

    int     total = 0;
    int     bad   = 0;
    int     cyc   = 0;
    bit     done  = 0;
    longint hist [4];
    longint cf   [4];
    longint exp_val_q [$];
    int     exp_cyc_q [$];
    string  exp_tag_q [$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input longint act, input longint expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic set_coefs(input longint c0, input longint c1, input longint c2, input longint c3);
        cf[0] = c0; cf[1] = c1; cf[2] = c2; cf[3] = c3;
        for (int k = 0; k < 4; k++) coef_i[k*CW +: CW] = CW'(cf[k]);
    endtask

    // driver: called at a negedge, returns gap negedges later
    task automatic send(input longint x, input int gap, input string tag);
        longint s = 0;
        for (int k = 3; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = x;
        for (int k = 0; k < 4; k++) s += cf[k] * hist[k];
        exp_val_q.push_back(s);
        exp_cyc_q.push_back(cyc + 7); // R3: six edges after the sampling edge
        exp_tag_q.push_back(tag);
        smp_valid_i = 1'b1; smp_data_i = DW'(x);
        @(negedge clk);
        smp_valid_i = 1'b0;
        repeat (gap - 1) @(negedge clk);
    endtask

    // strobe expected to be dropped: no model update, no queue entry
    task automatic send_drop(input longint x, input int gap);
        smp_valid_i = 1'b1; smp_data_i = DW'(x);
        @(negedge clk);
        smp_valid_i = 1'b0;
        repeat (gap - 1) @(negedge clk);
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && res_valid_o) begin
            if (exp_val_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R4: actual=unexpected result %0d expected=no result", res_data_o);
            end else begin
                string t = exp_tag_q.pop_front();
                check(t, longint'(res_data_o), exp_val_q.pop_front());
                check("R3 latency", longint'(cyc), longint'(exp_cyc_q.pop_front()));
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 4; k++) hist[k] = 0;
        set_coefs(1, 2, 3, 4);
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 valid", longint'(res_valid_o), 0);
        check("R1 data", longint'(res_data_o), 0);
        check("R1 ovr", longint'(ovr_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: impulse reads out coefficients in tap order
        send(1, 8, "R2 impulse c0");
        send(0, 8, "R2 impulse c1");
        send(0, 8, "R2 impulse c2");
        send(0, 8, "R2 impulse c3");
        send(0, 8, "R2 impulse flush");
        repeat (10) @(negedge clk);

        // R8: signed values with negative coefficients, idle gaps
        set_coefs(-3, 7, -11, 5);
        send(-100, 6, "R8 mixed sign");
        send(250, 6, "R8 mixed sign");
        send(-32768, 6, "R8 mixed sign");
        send(32767, 6, "R8 mixed sign");
        // R5: minimum spacing of four cycles (run_chain path)
        send(12, 4, "R5 back-to-back");
        send(-9, 4, "R5 back-to-back");
        send(31, 4, "R5 back-to-back");
        send(-4, 4, "R5 back-to-back");
        send(1000, 4, "R5 back-to-back");
        repeat (10) @(negedge clk);

        // R6/R7: strobes during a busy run are dropped
        check("R6 ovr before", longint'(ovr_o), 0);
        send(20, 1, "R6 kept before drop");
        send_drop(999, 1);
        send_drop(-777, 2);
        send(-6, 4, "R6 history unshifted");
        send(3, 8, "R6 history unshifted");
        check("R7 ovr set", longint'(ovr_o), 1);
        repeat (10) @(negedge clk);

        // R8: full-scale accumulation
        set_coefs(-32768, -32768, -32768, -32768);
        for (int i = 0; i < 4; i++) send(-32768, 4, "R8 full scale");
        send(32767, 4, "R8 full scale mixed");
        repeat (12) @(negedge clk);

        check("R4 all results seen", longint'(exp_val_q.size()), 0);
        check("R7 ovr sticky", longint'(ovr_o), 1);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule